// File: doc/BRIEF.md
# Transactional Register Snapshot Rename Unit

This unit is a register rename table and physical-register free pool extended so that architectural register state can be rolled back at transaction granularity. Each renamed destination takes the lowest-numbered free physical register, and the unit reports the previous mapping so that the reorder buffer can return it on graduation. A lookup port array translates source architectural registers to their newest physical register.

When a transaction-open instruction is decoded, the unit copies the current map, the set of physical registers that the map names, and the handler address into a small queue of pending snapshots. A pending snapshot takes effect only when its open instruction graduates. While a snapshot is in effect, any register it names that graduation would normally free is parked on a reserved list, so the pre-transaction values stay intact however many instructions run. Graduating the outermost close returns the parked registers to the pool and drops the snapshot. An abort reinstates the snapshot's map, rebuilds the pool, empties the pending queue and the nesting state, and one cycle later raises a redirect to the handler address. Open instructions that arrive inside an open transaction are folded into it and take no snapshot. Only one snapshot is ever in effect, so at most one map's worth of registers is pinned even when several transactions are in flight.

Top module: `trn_rename_top`

## Requirements
- R1: After reset, architectural register a maps to physical register a, physical registers NUM_ARCH and above are free, no redirect is raised and a lone decode is not stalled.
- R2: A decode with a destination that is not stalled is granted in the same cycle the lowest-numbered free physical register, reports the destination's previous physical register, and from the next cycle every lookup of that destination returns the new register.
- R3: Decode stalls, and changes no state, when it needs a destination and no physical register is free, or when it carries an outermost transaction-open while 2 snapshots are already pending.
- R4: A snapshot does not take effect before its open instruction graduates; an abort while no snapshot is in effect raises no redirect and leaves the map unchanged.
- R5: While a snapshot is in effect, a graduated free of a register that the snapshot names is held back and not reallocated; a free of any other register makes it allocatable at once.
- R6: Graduation of the outermost transaction-close returns every held register to the pool and drops the snapshot, after which an abort is ignored.
- R7: An abort while a snapshot is in effect restores the snapshot's map, leaves free exactly the registers the snapshot does not name, and raises redirect for exactly one cycle, in the cycle after the abort, carrying the handler address of the snapshot's open instruction.
- R8: An open decoded or graduated while a transaction is already open is folded into it: it takes no queue slot, causes no stall, and an abort redirects to the outermost handler address.
- R9: An abort discards all pending snapshots and both the decode-side and graduation-side nesting depth, so the next open is outermost and takes its own snapshot.
- R10: The current map always names exactly NUM_ARCH distinct physical registers, and no register is both free and held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is presented for decode |
| dec_begin | input | 1 | The decoded instruction opens a transaction |
| dec_end | input | 1 | The decoded instruction closes a transaction |
| dec_dst_valid | input | 1 | The decoded instruction writes a register |
| dec_dst_arch | input | AREG_W | Destination architectural register |
| dec_handler_pc | input | PC_W | Abort handler address carried by an open |
| dec_stall | output | 1 | Decode must hold this cycle |
| alloc_grant | output | 1 | A destination register was allocated |
| alloc_preg | output | PREG_W | Newly allocated physical register |
| alloc_prev_preg | output | PREG_W | Physical register previously mapped to the destination |
| lkp_arch | input | NUM_RD x AREG_W | Source architectural registers to translate |
| lkp_preg | output | NUM_RD x PREG_W | Current physical register of each source |
| grad_begin | input | 1 | A transaction-open instruction graduates |
| grad_end | input | 1 | A transaction-close instruction graduates |
| grad_free_valid | input | 1 | A graduating instruction releases a physical register |
| grad_free_preg | input | PREG_W | Physical register being released |
| abort | input | 1 | Abort the transaction in effect |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Handler address to restart at |

## Verification
The bench targets the window between decode and graduation of an open: an abort there must do nothing, while a design that armed the snapshot at decode would redirect and unwind younger renames. It frees a snapshot-named register inside a transaction and allocates again; a design without the reserved list would hand that register back out and corrupt the rollback value, and one that forgot to drain it at the close would leak it. Nested opens and a full pending queue are mixed before an abort, so that a design which queued inner opens would redirect to an inner handler, and one that kept stale pending entries or nesting depth after an abort would redirect to an older handler or not at all.

// File: rtl/trn_pkg.sv
package trn_pkg;

   typedef enum logic [1:0] {
      TC_NONE  = 2'd0,
      TC_OUTER = 2'd1,
      TC_INNER = 2'd2
   } txn_class_e;

endpackage

// File: rtl/trn_nest_track.sv
module trn_nest_track
   import trn_pkg::*;
#(
   parameter int DEPTH_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic en,
   input  logic open_i,
   input  logic close_i,
   output logic outer_open_o,
   output logic outer_close_o
);

   localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;

   logic [DEPTH_W-1:0] depth_q;
   txn_class_e         open_cls;
   txn_class_e         close_cls;

   always_comb begin
      open_cls  = TC_NONE;
      close_cls = TC_NONE;
      if (open_i)
         open_cls = (depth_q == '0) ? TC_OUTER : TC_INNER;
      if (close_i)
         close_cls = (depth_q == DEPTH_W'(1)) ? TC_OUTER : TC_INNER;
   end

   assign outer_open_o  = (open_cls == TC_OUTER);
   assign outer_close_o = (close_cls == TC_OUTER);

   always_ff @(posedge clk) begin
      if (!rst_n || flush)
         depth_q <= '0;
      else if (en && open_i)
         depth_q <= depth_q + DEPTH_W'(1);
      else if (en && close_i)
         depth_q <= depth_q - DEPTH_W'(1);
   end

   // R8: closes never outnumber opens, and the depth never wraps
   a_r8_close_balanced: assert property (@(posedge clk) disable iff (!rst_n)
      (en && close_i && !flush) |-> (depth_q != '0));
   a_r8_depth_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en && open_i && !flush) |-> (depth_q != DEPTH_MAX));

endmodule

// File: rtl/trn_snap_fifo.sv
module trn_snap_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 2,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("trn_snap_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [PTR_W-1:0] wr_q;
   logic [PTR_W-1:0] rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DEPTH-1:0][WIDTH-1:0] slot_q;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
   assign dout  = slot_q[rd_q];

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (push && !full && wr_q == PTR_W'(i))
            slot_q[i] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push && !full)
            wr_q <= step(wr_q);
         if (pop && !empty)
            rd_q <= step(rd_q);
         case ({push && !full, pop && !empty})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R3: a push never meets a full queue (decode must have stalled)
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> !full);
   // R4: a snapshot is only armed when one is pending
   a_r4_pop_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> !empty);

endmodule

// File: rtl/trn_free_pool.sv
module trn_free_pool #(
   parameter int NUM_PHYS   = 16,
   parameter int NUM_ARCH   = 8,
   parameter bit ALLOC_HIGH = 1'b0,
   localparam int PREG_W = $clog2(NUM_PHYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_req,
   output logic                alloc_ok,
   output logic [PREG_W-1:0]   alloc_idx,
   input  logic                rel_valid,
   input  logic [PREG_W-1:0]   rel_idx,
   input  logic                pin_valid,
   input  logic [NUM_PHYS-1:0] pin_mask,
   input  logic                drain,
   input  logic                restore
);

   logic [NUM_PHYS-1:0] free_q, free_d;
   logic [NUM_PHYS-1:0] held_q, held_d;

   assign alloc_ok = |free_q;

   generate
      if (ALLOC_HIGH) begin : g_pick_high
         always_comb begin
            alloc_idx = '0;
            for (int i = 0; i < NUM_PHYS; i++)
               if (free_q[i]) alloc_idx = PREG_W'(i);
         end
      end else begin : g_pick_low
         always_comb begin
            alloc_idx = '0;
            for (int i = NUM_PHYS - 1; i >= 0; i--)
               if (free_q[i]) alloc_idx = PREG_W'(i);
         end
      end
   endgenerate

   always_comb begin
      free_d = free_q;
      held_d = held_q;
      if (restore) begin
         free_d = ~pin_mask;
         held_d = '0;
      end else begin
         if (alloc_req && alloc_ok)
            free_d[alloc_idx] = 1'b0;
         if (drain) begin
            free_d = free_d | held_q;
            held_d = '0;
         end
         if (rel_valid) begin
            if (pin_valid && pin_mask[rel_idx] && !drain)
               held_d[rel_idx] = 1'b1;
            else
               free_d[rel_idx] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PHYS; i++)
            free_q[i] <= (i >= NUM_ARCH);
         held_q <= '0;
      end else begin
         free_q <= free_d;
         held_q <= held_d;
      end
   end

   // R10: a register is never both free and held back
   a_r10_free_held_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (free_q & held_q) == '0);
   // R5: only registers named by the snapshot in effect are held
   a_r5_held_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q & ~pin_mask) == '0);
   // R6: nothing is held while no snapshot is in effect
   a_r6_idle_nothing_held: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_valid |-> (held_q == '0));
   // R2: a released register must have been in use
   a_r2_release_in_use: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !restore) |-> !free_q[rel_idx]);

endmodule

// File: rtl/trn_rename_top.sv
module trn_rename_top #(
   parameter int NUM_ARCH   = 8,
   parameter int NUM_PHYS   = 16,
   parameter int PC_W       = 16,
   parameter int NUM_RD     = 2,
   parameter int SNAP_DEPTH = 2,
   parameter int NEST_W     = 4,
   parameter bit ALLOC_HIGH = 1'b0,
   localparam int AREG_W = $clog2(NUM_ARCH),
   localparam int PREG_W = $clog2(NUM_PHYS),
   localparam int MAP_W  = NUM_ARCH * PREG_W,
   localparam int SNAP_W = PC_W + NUM_PHYS + MAP_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           dec_valid,
   input  logic                           dec_begin,
   input  logic                           dec_end,
   input  logic                           dec_dst_valid,
   input  logic [AREG_W-1:0]              dec_dst_arch,
   input  logic [PC_W-1:0]                dec_handler_pc,
   output logic                           dec_stall,
   output logic                           alloc_grant,
   output logic [PREG_W-1:0]              alloc_preg,
   output logic [PREG_W-1:0]              alloc_prev_preg,
   input  logic [NUM_RD-1:0][AREG_W-1:0]  lkp_arch,
   output logic [NUM_RD-1:0][PREG_W-1:0]  lkp_preg,
   input  logic                           grad_begin,
   input  logic                           grad_end,
   input  logic                           grad_free_valid,
   input  logic [PREG_W-1:0]              grad_free_preg,
   input  logic                           abort,
   output logic                           redirect_valid,
   output logic [PC_W-1:0]                redirect_pc
);

   generate
      if (NUM_PHYS <= NUM_ARCH) begin : g_bad_phys
         $error("trn_rename_top: NUM_PHYS must exceed NUM_ARCH");
      end
      if (NUM_ARCH < 2 || (1 << AREG_W) != NUM_ARCH) begin : g_bad_arch
         $error("trn_rename_top: NUM_ARCH must be a power of two, at least 2");
      end
      if (NUM_RD < 1) begin : g_bad_rd
         $error("trn_rename_top: NUM_RD must be at least 1");
      end
   endgenerate

   typedef logic [NUM_ARCH-1:0][PREG_W-1:0] map_t;

   map_t                map_q;
   logic [NUM_PHYS-1:0] saved_q;
   logic                act_valid_q;
   map_t                act_map_q;
   logic [NUM_PHYS-1:0] act_saved_q;
   logic [PC_W-1:0]     act_pc_q;
   logic                redir_v_q;
   logic [PC_W-1:0]     redir_pc_q;

   logic abort_take;
   logic dec_outer_open, dec_outer_close;
   logic grad_outer_open, grad_outer_close;
   logic dec_accept, ren_fire, snap_push, snap_pop;
   logic q_full, q_empty;
   logic pool_ok;
   logic [PREG_W-1:0] pool_idx;
   logic [SNAP_W-1:0] snap_in, snap_out;
   logic [PREG_W-1:0] prev_preg;

   assign abort_take = abort && act_valid_q;

   trn_nest_track #(.DEPTH_W(NEST_W)) u_dec_nest (
      .clk(clk), .rst_n(rst_n), .flush(abort_take), .en(dec_accept),
      .open_i(dec_valid && dec_begin), .close_i(dec_valid && dec_end),
      .outer_open_o(dec_outer_open), .outer_close_o(dec_outer_close)
   );

   trn_nest_track #(.DEPTH_W(NEST_W)) u_grad_nest (
      .clk(clk), .rst_n(rst_n), .flush(abort_take), .en(!abort_take),
      .open_i(grad_begin), .close_i(grad_end),
      .outer_open_o(grad_outer_open), .outer_close_o(grad_outer_close)
   );

   assign dec_stall = dec_valid &&
                      ((dec_begin && dec_outer_open && q_full) ||
                       (dec_dst_valid && !pool_ok));
   assign dec_accept  = dec_valid && !dec_stall && !abort_take;
   assign ren_fire    = dec_accept && dec_dst_valid;
   assign snap_push   = dec_accept && dec_begin && dec_outer_open;
   assign snap_pop    = grad_outer_open && !abort_take;

   assign prev_preg       = map_q[dec_dst_arch];
   assign alloc_grant     = ren_fire;
   assign alloc_preg      = pool_idx;
   assign alloc_prev_preg = prev_preg;

   assign snap_in = {dec_handler_pc, saved_q, map_q};

   trn_snap_fifo #(.WIDTH(SNAP_W), .DEPTH(SNAP_DEPTH)) u_pending (
      .clk(clk), .rst_n(rst_n), .flush(abort_take),
      .push(snap_push), .din(snap_in),
      .pop(snap_pop), .dout(snap_out),
      .full(q_full), .empty(q_empty)
   );

   trn_free_pool #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .ALLOC_HIGH(ALLOC_HIGH)) u_pool (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(ren_fire), .alloc_ok(pool_ok), .alloc_idx(pool_idx),
      .rel_valid(grad_free_valid && !abort_take), .rel_idx(grad_free_preg),
      .pin_valid(act_valid_q), .pin_mask(act_saved_q),
      .drain(grad_outer_close && !abort_take),
      .restore(abort_take)
   );

   for (genvar r = 0; r < NUM_RD; r++) begin : g_lookup
      assign lkp_preg[r] = map_q[lkp_arch[r]];
   end

   // Working map and the set of registers it names
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARCH; a++)
            map_q[a] <= PREG_W'(a);
         for (int p = 0; p < NUM_PHYS; p++)
            saved_q[p] <= (p < NUM_ARCH);
      end else if (abort_take) begin
         map_q   <= act_map_q;
         saved_q <= act_saved_q;
      end else if (ren_fire) begin
         map_q[dec_dst_arch] <= pool_idx;
         for (int p = 0; p < NUM_PHYS; p++) begin
            if (PREG_W'(p) == pool_idx)
               saved_q[p] <= 1'b1;
            else if (PREG_W'(p) == prev_preg)
               saved_q[p] <= 1'b0;
         end
      end
   end

   // Snapshot in effect
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_valid_q <= 1'b0;
         act_map_q   <= '0;
         act_saved_q <= '0;
         act_pc_q    <= '0;
      end else if (abort_take) begin
         act_valid_q <= 1'b0;
      end else if (grad_outer_open) begin
         act_valid_q <= 1'b1;
         act_map_q   <= snap_out[MAP_W-1:0];
         act_saved_q <= snap_out[MAP_W +: NUM_PHYS];
         act_pc_q    <= snap_out[SNAP_W-1 -: PC_W];
      end else if (grad_outer_close) begin
         act_valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redir_v_q  <= 1'b0;
         redir_pc_q <= '0;
      end else begin
         redir_v_q <= abort_take;
         if (abort_take)
            redir_pc_q <= act_pc_q;
      end
   end

   assign redirect_valid = redir_v_q;
   assign redirect_pc    = redir_pc_q;

   // R10: the working map always names NUM_ARCH registers
   a_r10_saved_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(saved_q) == NUM_ARCH);
   // R4: one snapshot in effect at a time
   a_r4_single_active: assert property (@(posedge clk) disable iff (!rst_n)
      (grad_outer_open && !abort_take) |-> !act_valid_q);
   // R4: an outermost close always has its snapshot pending or in effect
   a_r4_close_has_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_accept && dec_outer_close) |-> (!q_empty || act_valid_q));
   // R7: redirect is a one-cycle pulse following a taken abort
   a_r7_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> !redirect_valid);
   a_r7_redirect_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(redirect_valid) |-> $past(abort && act_valid_q));
   // R3: a stalled decode changes neither map nor nesting
   a_r3_stall_no_rename: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_stall && !abort_take) |=> $stable(map_q));

endmodule

// File: tb/trn_rename_top_test.sv
module trn_rename_top_test;

   localparam int CLK_P  = 10;
   localparam int NARCH  = 8;
   localparam int NPHYS  = 16;
   localparam int PCW    = 16;
   localparam int NRD    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dec_valid, dec_begin, dec_end, dec_dst_valid;
   logic [2:0] dec_dst_arch;
   logic [PCW-1:0] dec_handler_pc;
   logic dec_stall, alloc_grant;
   logic [3:0] alloc_preg, alloc_prev_preg;
   logic [NRD-1:0][2:0] lkp_arch;
   logic [NRD-1:0][3:0] lkp_preg;
   logic grad_begin, grad_end, grad_free_valid;
   logic [3:0] grad_free_preg;
   logic abort;
   logic redirect_valid;
   logic [PCW-1:0] redirect_pc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   trn_rename_top #(.NUM_ARCH(NARCH), .NUM_PHYS(NPHYS), .PC_W(PCW), .NUM_RD(NRD)) uut (
      .clk(clk), .rst_n(rst_n),
      .dec_valid(dec_valid), .dec_begin(dec_begin), .dec_end(dec_end),
      .dec_dst_valid(dec_dst_valid), .dec_dst_arch(dec_dst_arch),
      .dec_handler_pc(dec_handler_pc),
      .dec_stall(dec_stall), .alloc_grant(alloc_grant),
      .alloc_preg(alloc_preg), .alloc_prev_preg(alloc_prev_preg),
      .lkp_arch(lkp_arch), .lkp_preg(lkp_preg),
      .grad_begin(grad_begin), .grad_end(grad_end),
      .grad_free_valid(grad_free_valid), .grad_free_preg(grad_free_preg),
      .abort(abort),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
   );

   // Table: op 0 = rename (arch -> e_new, e_old), 1 = graduate free of preg,
   // 2 = lookup (arch -> e_new). Walked from reset, rows R2.
   typedef struct packed {
      logic [1:0] op;
      logic [2:0] arch;
      logic [3:0] preg;
      logic [3:0] e_new;
      logic [3:0] e_old;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 3'd1, 4'd0, 4'd8,  4'd1},
      '{2'd0, 3'd2, 4'd0, 4'd9,  4'd2},
      '{2'd0, 3'd1, 4'd0, 4'd10, 4'd8},
      '{2'd1, 3'd0, 4'd1, 4'd0,  4'd0},
      '{2'd0, 3'd3, 4'd0, 4'd1,  4'd3},
      '{2'd2, 3'd1, 4'd0, 4'd10, 4'd0},
      '{2'd2, 3'd3, 4'd0, 4'd1,  4'd0},
      '{2'd1, 3'd0, 4'd8, 4'd0,  4'd0},
      '{2'd1, 3'd0, 4'd2, 4'd0,  4'd0},
      '{2'd0, 3'd7, 4'd0, 4'd2,  4'd7},
      '{2'd0, 3'd0, 4'd0, 4'd8,  4'd0},
      '{2'd2, 3'd7, 4'd0, 4'd2,  4'd0},
      '{2'd2, 3'd2, 4'd0, 4'd9,  4'd0},
      '{2'd2, 3'd0, 4'd0, 4'd8,  4'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic idle();
      dec_valid = 0; dec_begin = 0; dec_end = 0; dec_dst_valid = 0;
      dec_dst_arch = '0; dec_handler_pc = '0;
      grad_begin = 0; grad_end = 0; grad_free_valid = 0; grad_free_preg = '0;
      abort = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      tick(); tick();
      rst_n = 1;
   endtask

   task automatic ren(input int arch, input int e_new, input int e_old, input string req);
      dec_valid = 1; dec_dst_valid = 1; dec_dst_arch = 3'(arch);
      #1;
      chk(req, {31'd0, alloc_grant}, 1);
      chk(req, {28'd0, alloc_preg}, 32'(e_new));
      chk(req, {28'd0, alloc_prev_preg}, 32'(e_old));
      tick(); idle();
   endtask

   task automatic lkp(input int arch, input int e, input string req);
      lkp_arch[0] = 3'(arch);
      #1;
      chk(req, {28'd0, lkp_preg[0]}, 32'(e));
   endtask

   task automatic open_dec(input int pc, input int e_stall, input string req);
      dec_valid = 1; dec_begin = 1; dec_handler_pc = PCW'(pc);
      #1;
      chk(req, {31'd0, dec_stall}, 32'(e_stall));
      tick(); idle();
   endtask

   task automatic close_dec();
      dec_valid = 1; dec_end = 1;
      tick(); idle();
   endtask

   task automatic grad_open();
      grad_begin = 1; tick(); idle();
   endtask

   task automatic grad_close();
      grad_end = 1; tick(); idle();
   endtask

   task automatic grad_free(input int p);
      grad_free_valid = 1; grad_free_preg = 4'(p);
      tick(); idle();
   endtask

   task automatic do_abort(input int e_valid, input int e_pc, input string req);
      abort = 1;
      tick();
      abort = 0;
      chk(req, {31'd0, redirect_valid}, 32'(e_valid));
      if (e_valid != 0)
         chk(req, {16'd0, redirect_pc}, 32'(e_pc));
      tick();
      chk(req, {31'd0, redirect_valid}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle();
      lkp_arch = '0;
      do_reset();

      // R1: reset state
      for (int a = 0; a < NARCH; a++) begin
         lkp_arch[1] = 3'(a);
         #1;
         chk("R1 identity map", {28'd0, lkp_preg[1]}, 32'(a));
      end
      chk("R1 no redirect", {31'd0, redirect_valid}, 0);
      dec_valid = 1; dec_dst_valid = 1; dec_dst_arch = 3'd5;
      #1;
      chk("R1 no stall", {31'd0, dec_stall}, 0);
      chk("R1 first alloc", {28'd0, alloc_preg}, 32'(NARCH));
      idle();
      #1;

      // R2: table of renames, frees and lookups
      for (int i = 0; i < NVEC; i++) begin
         case (VEC[i].op)
            2'd0: ren(int'(VEC[i].arch), int'(VEC[i].e_new), int'(VEC[i].e_old), "R2 rename");
            2'd1: grad_free(int'(VEC[i].preg));
            default: lkp(int'(VEC[i].arch), int'(VEC[i].e_new), "R2 lookup");
         endcase
      end

      // R3: stall when no register is free
      do_reset();
      for (int a = 0; a < NARCH; a++)
         ren(a, NARCH + a, a, "R3 fill");
      dec_valid = 1; dec_dst_valid = 1; dec_dst_arch = 3'd0;
      #1;
      chk("R3 stall empty pool", {31'd0, dec_stall}, 1);
      chk("R3 no grant", {31'd0, alloc_grant}, 0);
      tick(); idle();
      lkp(0, 8, "R3 stalled no change");
      grad_free(0);
      ren(1, 0, 9, "R3 freed reg reused");

      // R4 / R5 / R6
      do_reset();
      open_dec(16'h1234, 0, "R4 open accepted");
      ren(1, 8, 1, "R4 rename in open txn");
      do_abort(0, 0, "R4 abort before graduation ignored");
      lkp(1, 8, "R4 map kept");
      grad_open();
      grad_free(1);
      ren(2, 9, 2, "R5 held reg not reused");
      grad_free(2);
      close_dec();
      grad_close();
      ren(3, 1, 3, "R6 held reg released");
      ren(4, 2, 4, "R6 second held reg released");
      do_abort(0, 0, "R6 snapshot dropped");
      lkp(4, 2, "R6 map after ignored abort");

      // R5 / R7
      do_reset();
      open_dec(16'h0ABC, 0, "R7 open");
      grad_open();
      ren(1, 8, 1, "R7 rename a");
      ren(1, 9, 8, "R7 rename b");
      grad_free(1);
      grad_free(8);
      ren(2, 8, 2, "R5 unnamed reg reused");
      do_abort(1, 16'h0ABC, "R7 redirect");
      lkp(1, 1, "R7 map restored a1");
      lkp(2, 2, "R7 map restored a2");
      ren(5, 8, 5, "R7 pool rebuilt");

      // R8 / R9 / R3 queue full
      do_reset();
      open_dec(16'h0100, 0, "R8 outer open");
      open_dec(16'h0200, 0, "R8 nested open no stall");
      close_dec();
      close_dec();
      open_dec(16'h0300, 0, "R8 second outer open");
      close_dec();
      open_dec(16'h03FF, 1, "R3 pending queue full");
      grad_open();
      grad_open();
      ren(1, 8, 1, "R8 rename");
      do_abort(1, 16'h0100, "R8 outermost handler");
      lkp(1, 1, "R8 map restored");
      open_dec(16'h0400, 0, "R9 open after abort");
      grad_open();
      do_abort(1, 16'h0400, "R9 pending discarded");

      // R10: every architectural register maps to a distinct register
      begin
         logic [NPHYS-1:0] seen;
         seen = '0;
         for (int a = 0; a < NARCH; a++) begin
            lkp_arch[0] = 3'(a);
            #1;
            seen[lkp_preg[0]] = 1'b1;
         end
         chk("R10 distinct mapping", 32'($countones(seen)), 32'(NARCH));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule